// File: doc/BRIEF.md
# Delayed-Replica Stimulus Capture Unit

This unit wraps a small accumulator with a second copy of the same logic and a circular stimulus store. The live accumulator sees every input as it arrives. Each cycle's input pair (valid flag and data) is also written into a ring of DEPTH entries. The replica copy reads its input from that ring, so it runs exactly DEPTH cycles behind the live copy. When a trigger qualifies, the replica and the ring stop on the same clock edge, while the live copy keeps accumulating. What remains is the replica state from DEPTH cycles before the trigger and every input applied since then. Replaying the stored inputs onto the frozen replica value reproduces the live state at the moment of the trigger.

There are two trigger sources. A range watch fires when the live sum leaves a programmed window. A burst rule fires when the valid input stays high for more than BURST_MAX consecutive cycles. A registered address/data port reads out the frozen replica value, the trigger cause and the stored inputs, oldest first.

A three-state machine controls the unit:
- FILL: the ring is being primed and the replica is held. This state is entered at reset and on the `rearm` transition.
- RUN: the replica steps. FILL leaves for RUN on the `fill_done` transition after DEPTH cycles.
- FROZEN: RUN enters it on the `trigger` transition. It returns to FILL on the `rearm` transition.

Top module: `snap_capture`

## Requirements
- R1: The live sum adds `in_data` on every edge where `in_valid` is high, in every state including FROZEN, and resets to 0.
- R2: Outside FROZEN, every edge stores the pair {valid at bit DATA_W, data in the low bits} into the ring. The replica consumes each stored pair exactly DEPTH edges later. As a result, the frozen replica value equals the live sum from DEPTH edges before the freeze edge.
- R3: After reset or rearm the unit spends exactly DEPTH edges in FILL. On the first FILL edge the replica loads the current live sum, and it then holds that value. Triggers are ignored in FILL.
- R4: The range trigger is raised when `range_en` is high and the live sum (the value before the edge) is below `lo_bound` or above `hi_bound`.
- R5: The burst trigger is raised when `burst_en` and `in_valid` are both high on an edge that follows BURST_MAX consecutive valid edges.
- R6: A trigger in RUN freezes the unit on that edge. Neither the ring nor the replica takes that edge's input, and `frozen` is high after the edge.
- R7: While the unit is FROZEN, further triggers have no effect: the cause, the replica value and the stored history stay unchanged.
- R8: `rd_data` is registered and reflects `rd_addr` one edge later. The address decodes as follows:
  - MSB 0, offset 0: the replica sum.
  - MSB 0, offset 1: the cause, with bit0 for range and bit1 for burst. Both bits are set if both triggers fired on the freeze edge.
  - MSB 1: the low bits give index i, which returns the i-th oldest stored pair, zero-extended.
- R9: `rearm` moves FROZEN to FILL. In FILL or RUN it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input qualifier for the live copy |
| in_data | input | DATA_W | Input value to accumulate |
| lo_bound | input | SUM_W | Lower limit of the range watch |
| hi_bound | input | SUM_W | Upper limit of the range watch |
| range_en | input | 1 | Enables the range trigger |
| burst_en | input | 1 | Enables the burst trigger |
| rearm | input | 1 | Leaves FROZEN and restarts the fill |
| rd_addr | input | PW+1 | Readout address |
| rd_data | output | WORD_W | Readout word, one edge after the address |
| live_sum | output | SUM_W | Live accumulator value |
| frozen | output | 1 | High in FROZEN |

## Verification
The range watch and the burst rule can both qualify on the same edge, and the cause word must then show both bits. A directed case provokes this by holding `in_valid` high for BURST_MAX edges and dropping `hi_bound` below the live sum on the very edge that completes the burst. The bench predicts the cause with its own model and compares it with the readout at offset 1. It also replays the read-back history onto the read-back replica value and checks that the result matches the live sum it saw at the freeze edge.

// File: rtl/snap_pkg.sv
package snap_pkg;
    typedef enum logic [1:0] {
        ST_FILL   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FROZEN = 2'd2
    } cap_st_e;

    localparam int CAUSE_RANGE = 0;
    localparam int CAUSE_BURST = 1;
endpackage

// File: rtl/snap_accum.sv
module snap_accum #(
    parameter int DATA_W = 8,
    parameter int SUM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SUM_W-1:0]  load_val,
    input  logic              step,
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    output logic [SUM_W-1:0]  sum
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            sum <= '0;
        else if (load)
            sum <= load_val;
        else if (step && valid)
            sum <= sum + SUM_W'(data);
    end
endmodule

// File: rtl/snap_ring.sv
module snap_ring #(
    parameter int DEPTH = 256,
    parameter int W     = 9,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_word,
    output logic [W-1:0]  old_word,
    output logic [PW-1:0] wp,
    input  logic [PW-1:0] rd_idx,
    output logic [W-1:0]  rd_word
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wp] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            wp <= '0;
        else if (wr_en)
            wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
    end

    assign old_word = mem[wp];
    assign rd_word  = mem[rd_idx];
endmodule

// File: rtl/snap_trig.sv
module snap_trig #(
    parameter int SUM_W     = 16,
    parameter int BURST_MAX = 8,
    localparam int CW       = $clog2(BURST_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [SUM_W-1:0] sum,
    input  logic [SUM_W-1:0] lo,
    input  logic [SUM_W-1:0] hi,
    input  logic             range_en,
    input  logic             burst_en,
    output logic             raw_range,
    output logic             raw_burst
);
    logic [CW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (!rst_n || !valid)
            run_len <= '0;
        else if (run_len != CW'(BURST_MAX))
            run_len <= run_len + 1'b1;
    end

    assign raw_range = range_en && ((sum < lo) || (sum > hi));
    assign raw_burst = burst_en && valid && (run_len == CW'(BURST_MAX));
endmodule

// File: rtl/snap_capture.sv
module snap_capture import snap_pkg::*; #(
    parameter int DATA_W    = 8,
    parameter int SUM_W     = 16,
    parameter int DEPTH     = 256,
    parameter int BURST_MAX = 8,
    localparam int PW       = $clog2(DEPTH),
    localparam int SW       = DATA_W + 1,
    localparam int WORD_W   = (SUM_W > SW) ? SUM_W : SW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [SUM_W-1:0]  lo_bound,
    input  logic [SUM_W-1:0]  hi_bound,
    input  logic              range_en,
    input  logic              burst_en,
    input  logic              rearm,
    input  logic [PW:0]       rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic [SUM_W-1:0]  live_sum,
    output logic              frozen
);
    cap_st_e        st_q, st_d;
    logic [PW-1:0]  fill_cnt, wp, frz_wp, rd_idx;
    logic [PW:0]    idx_sum;
    logic [SW-1:0]  old_word, rd_word;
    logic [SUM_W-1:0] rep_sum;
    logic [1:0]     cause_q;
    logic           raw_range, raw_burst, trig, fill_done;
    logic           wr_en, rep_load, rep_step;

    // live copy: never gated
    snap_accum #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_live (
        .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0), .step(1'b1),
        .valid(in_valid), .data(in_data), .sum(live_sum)
    );

    // replica: fed from the ring, DEPTH edges behind
    snap_accum #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_replica (
        .clk(clk), .rst_n(rst_n), .load(rep_load), .load_val(live_sum), .step(rep_step),
        .valid(old_word[DATA_W]), .data(old_word[DATA_W-1:0]), .sum(rep_sum)
    );

    snap_ring #(.DEPTH(DEPTH), .W(SW)) u_ring (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word({in_valid, in_data}),
        .old_word(old_word), .wp(wp), .rd_idx(rd_idx), .rd_word(rd_word)
    );

    snap_trig #(.SUM_W(SUM_W), .BURST_MAX(BURST_MAX)) u_trig (
        .clk(clk), .rst_n(rst_n), .valid(in_valid), .sum(live_sum),
        .lo(lo_bound), .hi(hi_bound), .range_en(range_en), .burst_en(burst_en),
        .raw_range(raw_range), .raw_burst(raw_burst)
    );

    assign fill_done = (fill_cnt == PW'(DEPTH - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_FILL;
        else
            st_q <= st_d;
    end

    // next state and per-state controls
    always_comb begin
        st_d     = st_q;
        trig     = 1'b0;
        wr_en    = 1'b0;
        rep_load = 1'b0;
        rep_step = 1'b0;
        unique case (st_q)
            ST_FILL: begin
                wr_en    = 1'b1;
                rep_load = (fill_cnt == '0);
                if (fill_done)
                    st_d = ST_RUN;
            end
            ST_RUN: begin
                trig     = raw_range || raw_burst;
                wr_en    = !trig;
                rep_step = !trig;
                if (trig)
                    st_d = ST_FROZEN;
            end
            ST_FROZEN: begin
                if (rearm)
                    st_d = ST_FILL;
            end
            default: st_d = ST_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt <= '0;
            frz_wp   <= '0;
            cause_q  <= '0;
        end else begin
            fill_cnt <= (st_q == ST_FILL) ? fill_cnt + 1'b1 : '0;
            if (trig) begin
                frz_wp                <= wp;
                cause_q[CAUSE_RANGE] <= raw_range;
                cause_q[CAUSE_BURST] <= raw_burst;
            end
        end
    end

    // readout: oldest stored pair sits at the write pointer captured at freeze
    assign idx_sum = {1'b0, frz_wp} + {1'b0, rd_addr[PW-1:0]};
    assign rd_idx  = (idx_sum >= (PW+1)'(DEPTH)) ? PW'(idx_sum - (PW+1)'(DEPTH))
                                                 : idx_sum[PW-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_addr[PW])
            rd_data <= WORD_W'(rd_word);
        else if (rd_addr[PW-1:0] == '0)
            rd_data <= WORD_W'(rep_sum);
        else if (rd_addr[PW-1:0] == PW'(1))
            rd_data <= WORD_W'(cause_q);
        else
            rd_data <= '0;
    end

    assign frozen = (st_q == ST_FROZEN);
endmodule

// File: rtl/snap_capture_chk.sv
module snap_capture_chk import snap_pkg::*; #(
    parameter int DEPTH = 256,
    parameter int SUM_W = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frozen,
    input logic             rearm,
    input logic             wr_en,
    input cap_st_e          st,
    input logic [PW-1:0]    fill_cnt,
    input logic [PW-1:0]    wp,
    input logic [SUM_W-1:0] rep_sum,
    input logic [1:0]       cause
);
    // R6: the freeze edge updates neither the ring pointer nor the replica
    a_r6_freeze_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frozen) |-> ($stable(wp) && $stable(rep_sum)));

    // R6: a freeze always records a cause
    a_r6_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frozen) |-> (cause != 2'b00));

    // R7: without rearm, frozen state and captured contents persist
    a_r7_stay_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !rearm) |=> (frozen && $stable(wp) && $stable(rep_sum) && $stable(cause)));

    // R3: after the first fill edge the replica holds
    a_r3_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FILL && fill_cnt != '0) |=> $stable(rep_sum));

    // R2: every stored pair advances the pointer by one with wrap
    a_r2_wp_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wp == (($past(wp) == PW'(DEPTH - 1)) ? '0 : $past(wp) + 1'b1)));
endmodule

bind snap_capture snap_capture_chk #(.DEPTH(DEPTH), .SUM_W(SUM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frozen(frozen), .rearm(rearm), .wr_en(wr_en),
    .st(st_q), .fill_cnt(fill_cnt), .wp(wp), .rep_sum(rep_sum), .cause(cause_q)
);

// File: tb/snap_capture_bench.sv
`timescale 1ns/1ps
module snap_capture_bench;
    localparam int N  = 256;
    localparam int BM = 8;

    logic        clk = 0, rst_n = 0;
    logic        b_valid = 0, b_range = 0, b_burst = 0, b_rearm = 0;
    logic [7:0]  b_data = 0;
    logic [15:0] b_lo = 0, b_hi = 16'hFFFF;
    logic [8:0]  b_addr = 0;
    logic [15:0] rd_data, live_sum;
    logic        frozen;

    snap_capture u_snap_capture (
        .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_data(b_data),
        .lo_bound(b_lo), .hi_bound(b_hi), .range_en(b_range), .burst_en(b_burst),
        .rearm(b_rearm), .rd_addr(b_addr), .rd_data(rd_data),
        .live_sum(live_sum), .frozen(frozen)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_bad = 0, ecount = 0;
    logic [8:0]  hist_in   [0:8191];
    logic [15:0] hist_live [0:8191];
    logic [15:0] m_live = 0;
    int          m_burst = 0, m_st = 0, m_fill = 0, m_t = 0;
    logic [1:0]  m_cause = 0;

    task automatic ck(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic rnd(input int pct);
        b_valid = ($urandom % 100) < pct;
        b_data  = 8'($urandom);
    endtask

    // one clock edge plus the reference model update
    task automatic tick();
        logic rr, rb, tr;
        int e;
        e = ecount;
        hist_in[e]   = {b_valid, b_data};
        hist_live[e] = m_live;
        rr = b_range && ((m_live < b_lo) || (m_live > b_hi));
        rb = b_burst && b_valid && (m_burst == BM);
        tr = (rr || rb) && (m_st == 1);
        @(posedge clk); #1;
        if (b_valid) m_live = m_live + 16'(b_data);
        m_burst = b_valid ? ((m_burst == BM) ? BM : m_burst + 1) : 0;
        case (m_st)
            0: begin if (m_fill == N - 1) m_st = 1; m_fill++; end
            1: if (tr) begin m_st = 2; m_t = e; m_cause = {rb, rr}; end
            default: if (b_rearm) begin m_st = 0; m_fill = 0; end
        endcase
        ecount++;
        ck(live_sum == m_live, "R1 live sum", live_sum, m_live);
        ck(frozen == (m_st == 2), "R6 R3 frozen flag", frozen, m_st == 2);
    endtask

    task automatic rd(input logic [8:0] a, output logic [15:0] v);
        b_addr = a;
        rnd(50);
        tick();
        v = rd_data;
    endtask

    task automatic read_all();
        logic [15:0] v, rep, acc;
        rd(9'h000, rep);
        ck(rep == hist_live[m_t - N], "R2 replica value", rep, hist_live[m_t - N]);
        rd(9'h001, v);
        ck(v == 16'(m_cause), "R8 cause word", v, m_cause);
        acc = rep;
        for (int i = 0; i < N; i++) begin
            rd({1'b1, 8'(i)}, v);
            ck(v == 16'(hist_in[m_t - N + i]), "R8 stimulus oldest first", v, hist_in[m_t - N + i]);
            if (v[8]) acc = acc + 16'(v[7:0]);
        end
        ck(acc == hist_live[m_t], "R2 replay matches live at freeze", acc, hist_live[m_t]);
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog act=%0d exp=done", ecount);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v, rep0;
        logic [1:0]  c0;
        int r;
        void'($urandom(32'd7051));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        ck(live_sum == 0, "R1 reset sum", live_sum, 0);
        ck(frozen == 0, "R6 reset frozen", frozen, 0);
        rd(9'h000, v);
        ck(v == 0, "R8 reset replica", v, 0);

        // fill and run, no triggers; rearm pulses must be ignored (R9)
        for (int k = 0; k < 400; k++) begin
            rnd(50);
            b_rearm = (k == 100) || (k == 300);
            tick();
        end
        b_rearm = 0;

        // range trigger (R4)
        b_range = 1; b_lo = 0; b_hi = m_live + 16'd1500;
        for (int k = 0; k < 300 && m_st != 2; k++) begin rnd(50); tick(); end
        ck(m_st == 2 && m_cause == 2'b01, "R4 range freeze", {m_st, m_cause}, {2'd2, 2'b01});
        read_all();

        // triggers while frozen are ignored (R7)
        rd(9'h000, rep0);
        rd(9'h001, v); c0 = v[1:0];
        b_burst = 1;
        for (int k = 0; k < 12; k++) begin b_valid = 1; b_data = 8'($urandom); tick(); end
        b_burst = 0;
        rd(9'h001, v);
        ck(v[1:0] == c0, "R7 cause unchanged", v, c0);
        rd(9'h000, v);
        ck(v == rep0, "R7 replica unchanged", v, rep0);

        // rearm with range violated: fill must ignore it, then freeze at first RUN edge (R3, R9)
        b_lo = 0; b_hi = 0;
        b_rearm = 1; rnd(50); r = ecount; tick(); b_rearm = 0;
        for (int k = 0; k < N + 4 && m_st != 2; k++) begin rnd(50); tick(); end
        ck(m_t == r + N + 1, "R3 fill length before trigger", m_t, r + N + 1);
        read_all();

        // range and burst on the same edge (R5)
        b_hi = 16'hFFFF; b_burst = 1;
        b_rearm = 1; b_valid = 0; tick(); b_rearm = 0;
        for (int k = 0; k < N; k++) begin b_valid = ecount[0]; b_data = 8'($urandom); tick(); end
        b_valid = 0; tick();
        for (int k = 0; k < BM; k++) begin b_valid = 1; b_data = 8'($urandom); tick(); end
        ck(frozen == 0, "R5 no burst trigger at limit", frozen, 0);
        b_valid = 1; b_hi = 0; tick();
        ck(frozen == 1 && m_cause == 2'b11, "R5 burst and range together", {frozen, m_cause}, 3'b111);
        read_all();

        b_range = 0; b_burst = 0;
        repeat (5) begin rnd(50); tick(); end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule